// File: doc/BRIEF.md
# Segmented DAC Input Decoder

This block is the clocked digital front end of a 10-bit segmented current-steering converter. Each clock it takes one offset-binary code word and a fold control, and registers both on the rising edge. In the next stage it can fold the code for symmetric waveform synthesis. If folding is on and the top bit of the captured word is zero, the nine lower bits are complemented. Otherwise the word passes unchanged.

The folded word is then split in two. The top four bits become fifteen thermometer lines, which drive equal-weight current cells. The bottom six bits are delayed by one register so that they reach the binary-weighted switch drivers on the same cycle as the thermometer lines. The complementary outputs carry the inverse drive for the second current output.

A check output gives the weight that the true lines steer, so the level can be compared against the folded code.

Top module: `seg_dac_front`

## Requirements
- R1: The code word and fold control are sampled only at the rising clock edge. Drive outputs show the result of a word two rising edges after it is sampled, and changes to the inputs between edges have no effect.
- R2: With the fold control low when sampled, the processed word equals the input word.
- R3: With the fold control high and bit 9 (the MSB) of the word low, bits 8..0 of the processed word are the complement of the input, and bit 9 stays 0.
- R4: With the fold control high and bit 9 high, the processed word equals the input word.
- R5: Thermometer line k (bit k of `therm_q`, k = 0..14) is high exactly when the value of bits 9..6 of the processed word is greater than k. The high lines are therefore contiguous from bit 0.
- R6: `bin_q` equals bits 5..0 of the processed word, in the same cycle as the matching thermometer lines.
- R7: Input 0x3FF with no fold drives every true line high. Input 0x000 with no fold drives every complementary line high.
- R8: `therm_n` and `bin_n` are the bitwise inverse of `therm_q` and `bin_q`. The weights steered to both sides (64 per thermometer line, 2^b for binary bit b) always sum to 1023.
- R9: The fold control applies to the word sampled on the same edge, and not to earlier or later words.
- R10: A synchronous active-high reset clears both stages. After the reset edge, all true lines are low, all complementary lines are high, and `wsum` is 0.
- R11: `wsum` equals 64 times the number of high thermometer lines plus the value of `bin_q`, and this equals the processed word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 10 | Offset-binary code word, bit 9 is MSB |
| fold_en | input | 1 | Fold control for the word sampled on the same edge |
| therm_q | output | 15 | Thermometer drive for the equal-weight cells |
| therm_n | output | 15 | Complementary thermometer drive |
| bin_q | output | 6 | Binary-weighted drive for the low bits |
| bin_n | output | 6 | Complementary binary drive |
| wsum | output | 10 | Weight steered to the true output |

## Verification
The properties assume that `din` and `fold_en` are two-valued at every rising edge. They also assume that two reset-free edges have passed before any output is compared with an earlier input. The checker counts those edges itself. The bench changes inputs only at the falling edge, or just after a rising edge when it is showing that mid-cycle changes are ignored. It releases reset only at a falling edge, so every sampled value is settled and known.

// File: rtl/seg_dac_front.sv
module seg_dac_front #(
  parameter int DW = 10,
  parameter int TW = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [DW-1:0]        din,
  input  logic                 fold_en,
  output logic [(2**TW)-2:0]   therm_q,
  output logic [(2**TW)-2:0]   therm_n,
  output logic [DW-TW-1:0]     bin_q,
  output logic [DW-TW-1:0]     bin_n,
  output logic [DW-1:0]        wsum
);
  localparam int LW = DW - TW;
  localparam int NT = (2**TW) - 1;

  logic [DW-1:0] in_r;
  logic          fold_r;
  logic [DW-1:0] folded;
  logic [NT-1:0] therm_d;
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_r   <= '0;
      fold_r <= 1'b0;
    end else begin
      in_r   <= din;
      fold_r <= fold_en;
    end
  end

  assign folded = (fold_r && !in_r[DW-1]) ? {1'b0, ~in_r[DW-2:0]} : in_r;

  for (genvar i = 0; i < NT; i++) begin : g_therm
    assign therm_d[i] = int'(folded[DW-1:LW]) > i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      therm_q <= '0;
      bin_q   <= '0;
    end else begin
      therm_q <= therm_d;
      bin_q   <= folded[LW-1:0];
    end
  end

  assign therm_n = ~therm_q;
  assign bin_n   = ~bin_q;

  always_comb begin
    cnt = '0;
    for (int k = 0; k < NT; k++) cnt = cnt + {{(TW-1){1'b0}}, therm_q[k]};
  end

  assign wsum = {cnt, bin_q};
endmodule

// File: rtl/seg_dac_front_chk.sv
module seg_dac_front_chk #(
  parameter int DW = 10,
  parameter int TW = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic [DW-1:0]        din,
  input logic                 fold_en,
  input logic [(2**TW)-2:0]   therm_q,
  input logic [(2**TW)-2:0]   therm_n,
  input logic [DW-TW-1:0]     bin_q,
  input logic [DW-TW-1:0]     bin_n,
  input logic [DW-1:0]        wsum
);
  localparam int LW = DW - TW;
  localparam int NT = (2**TW) - 1;

  logic [1:0] warm;
  logic       rst_d;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst) warm <= 2'd0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  p_pass_r2: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd2 && !$past(fold_en, 2)) |-> (wsum == $past(din, 2)));

  p_fold_r3: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd2 && $past(fold_en, 2) && !$past(din[DW-1], 2))
      |-> (wsum == {1'b0, ~$past(din[DW-2:0], 2)}));

  p_msbhi_r4: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd2 && $past(fold_en, 2) && $past(din[DW-1], 2)) |-> (wsum == $past(din, 2)));

  p_therm_shape_r5: assert property (@(posedge clk) disable iff (rst)
    (((therm_q + 1'b1) & therm_q) == '0));

  p_steer_r8: assert property (@(posedge clk) disable iff (rst)
    (($countones(therm_q) + $countones(therm_n)) * (2**LW) + int'(bin_q) + int'(bin_n))
      == (2**DW) - 1);

  always @(posedge clk) begin
    if (rst_d) begin
      p_reset_r10: assert (therm_q == '0 && bin_q == '0 && wsum == '0 &&
                           therm_n == '1 && bin_n == '1);
    end
  end
endmodule

bind seg_dac_front seg_dac_front_chk #(.DW(DW), .TW(TW)) u_chk (
  .clk(clk), .rst(rst), .din(din), .fold_en(fold_en),
  .therm_q(therm_q), .therm_n(therm_n), .bin_q(bin_q), .bin_n(bin_n), .wsum(wsum)
);

// File: tb/seg_dac_front_bench.sv
module seg_dac_front_bench;
  localparam int NV = 12;

  logic        clk = 1'b0;
  logic        rst;
  logic [9:0]  din;
  logic        fold_en;
  logic [14:0] therm_q, therm_n;
  logic [5:0]  bin_q, bin_n;
  logic [9:0]  wsum;
  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  seg_dac_front u_seg_dac_front (
    .clk(clk), .rst(rst), .din(din), .fold_en(fold_en),
    .therm_q(therm_q), .therm_n(therm_n), .bin_q(bin_q), .bin_n(bin_n), .wsum(wsum)
  );

  // {fold_en, din, expected processed word}
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 10'h3FF, 10'h3FF},
    {1'b0, 10'h000, 10'h000},
    {1'b0, 10'h155, 10'h155},
    {1'b1, 10'h000, 10'h1FF},
    {1'b1, 10'h3FF, 10'h3FF},
    {1'b1, 10'h155, 10'h0AA},
    {1'b1, 10'h2AA, 10'h2AA},
    {1'b1, 10'h0C3, 10'h13C},
    {1'b0, 10'h200, 10'h200},
    {1'b1, 10'h1FF, 10'h000},
    {1'b1, 10'h200, 10'h200},
    {1'b0, 10'h040, 10'h040}
  };

  task automatic check(input string req, input logic [9:0] exp);
    logic [14:0] et;
    et = '0;
    for (int k = 0; k < 15; k++) if (k < int'(exp[9:6])) et[k] = 1'b1;
    n_cmp++;
    if (therm_q !== et || bin_q !== exp[5:0] || therm_n !== ~et ||
        bin_n !== ~exp[5:0] || wsum !== exp) begin
      n_bad++;
      $display("FAIL %s: therm=%h/%h bin=%h/%h wsum=%h expected therm=%h/%h bin=%h/%h wsum=%h",
               req, therm_q, therm_n, bin_q, bin_n, wsum, et, ~et, exp[5:0], ~exp[5:0], exp);
    end
  endtask

  initial begin
    #4_000_000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1;
    din = '0;
    fold_en = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 initial reset", 10'h000);
    rst = 1'b0;

    // streamed table: R2/R3/R4/R5/R6/R7/R8/R9/R11 with fold toggling per word
    for (int j = 0; j < NV + 2; j++) begin
      @(negedge clk);
      if (j >= 2) check("R2/R3/R4/R5/R6/R7/R8/R9/R11 table", VEC[j-2][9:0]);
      if (j < NV) {fold_en, din} = VEC[j][20:10];
    end

    // R1: mid-cycle change is not captured
    @(negedge clk);
    din = 10'h2C5;
    fold_en = 1'b0;
    @(posedge clk);
    #2;
    din = 10'h013;
    fold_en = 1'b1;
    @(posedge clk);
    #2;
    fold_en = 1'b0;
    @(negedge clk);
    check("R1 edge sampling", 10'h2C5);
    @(negedge clk);
    check("R1 R3 second word folded", 10'h1EC);
    @(negedge clk);
    check("R1 R2 third word unfolded", 10'h013);

    // R10: synchronous reset mid-run
    din = 10'h3FF;
    fold_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R7 full scale before reset", 10'h3FF);
    rst = 1'b1;
    @(negedge clk);
    check("R10 mid-run reset", 10'h000);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R10 recovery after reset", 10'h3FF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule